// File: doc/BRIEF.md
# Charge Termination Slope Detector

This block watches two slow analog quantities during fast charging of a nickel-chemistry pack: the single-cell battery voltage and the thermistor voltage. It drives an external converter through a request/ready handshake, alternating between the two channels. Each filtered sample is the mean of a burst of conversions. The conversions in a burst are spaced so that the burst spans one full cycle of the low-frequency mains ripple. One filtered sample per channel is taken at the start of every long sample period.

Two termination tests run on every new pair of samples. The falling-voltage test fires when the cell voltage has dropped a set number of codes below the highest sample seen since the last restart. It is blocked while its enable is low, while the sample lies outside a window just below the maximum-cell-voltage level, and during a hold-off counted in samples after a restart. The temperature-rate test fires when the thermistor voltage has fallen a set number of codes below the sample taken two periods earlier. It is blocked while its enable is low and while the sample lies outside the window between the cutoff and low-temperature-fault levels. A start pulse restarts the sample timer and clears all history. Both results are one-cycle flags for the charge controller.

Top module: `charge_slope_detector`

## Requirements
- R1: Each burst holds 2^AVG_SHIFT conversion points. At each point one voltage conversion (`adc_chan`=0) is followed by one thermistor conversion (`adc_chan`=1), and only one request is outstanding at a time. At the end of the burst `sample_stb` is high for one cycle, and `v_avg`/`t_avg` equal the sum of that burst's codes for the channel shifted right by AVG_SHIFT (floor).
- R2: Bursts begin every PERIOD_CYC cycles. The first burst begins right after reset or a start pulse, and there are at least GAP_CYC idle cycles between conversion points. With a fixed converter latency, consecutive `sample_stb` pulses are exactly PERIOD_CYC cycles apart.
- R3: `dv_term` pulses when the voltage sample is at most peak − DV_DROP, where peak is the highest earlier voltage sample since the last start. Equality terminates; one code less of drop does not.
- R4: The voltage test only counts samples with mcv_lvl − span_lvl < v_avg < mcv_lvl. Both bounds are strict.
- R5: The voltage test is masked for the first `holdoff_samples` samples after reset or start. The temperature test is not affected by the hold-off.
- R6: While `dv_en` is low, `dv_term` stays low. The running peak keeps being tracked, and the enable may change between any two samples.
- R7: `dt_term` pulses when `dt_en` is high, two earlier samples exist, tco_lvl < t_avg < ltf_lvl, and t_avg ≤ (sample two periods back) − DT_DROP.
- R8: A start pulse clears the peak, the temperature history and the hold-off count. The first voltage sample and the first two temperature samples after a start never terminate, and no flag is raised in the cycle after a start.
- R9: `dv_term` and `dt_term` are high only in the cycle that directly follows `sample_stb`, and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart pulse: clears history, restarts the sample timer |
| dv_en | input | 1 | Enables the falling-voltage test |
| dt_en | input | 1 | Enables the temperature-rate test |
| holdoff_samples | input | 8 | Number of samples after start with the voltage test masked |
| mcv_lvl | input | ADC_W | Maximum-cell-voltage level, upper bound of voltage window |
| span_lvl | input | ADC_W | Width of the voltage window below mcv_lvl |
| tco_lvl | input | ADC_W | Temperature cutoff level, lower bound of thermistor window |
| ltf_lvl | input | ADC_W | Low-temperature-fault level, upper bound of thermistor window |
| adc_start | output | 1 | Conversion request, one cycle |
| adc_chan | output | 1 | Channel of the request: 0 voltage, 1 thermistor |
| adc_ready | input | 1 | Conversion result valid, one cycle |
| adc_data | input | ADC_W | Conversion result |
| sample_stb | output | 1 | New filtered samples on v_avg/t_avg |
| v_avg | output | ADC_W | Filtered cell-voltage sample |
| t_avg | output | ADC_W | Filtered thermistor sample |
| dv_term | output | 1 | Falling-voltage termination flag |
| dt_term | output | 1 | Temperature-rate termination flag |

## Verification
The hardest situation to reach from the ports is a voltage drop that lands exactly on the DV_DROP boundary right after a restart. In that state the hold-off count, the freshly cleared peak and the two-deep temperature history all interact. A start pulse arriving mid-run must discard a peak and history that would otherwise have fired both tests. Directed samples with noise-free conversions place the drop at the first sample after the hold-off ends, at equality, and one code short of it. Random samples with per-conversion noise, random enables and occasional restarts then sweep the windows and both edges of each threshold, against a bench model of peak, history and hold-off.

// File: rtl/csd_pkg.sv
// Shared types for the charge termination slope detector.
package csd_pkg;

    // Burst sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GAP,
        SQ_REQ_V,
        SQ_WAIT_V,
        SQ_REQ_T,
        SQ_WAIT_T,
        SQ_DONE
    } seq_state_t;

    localparam logic CH_VOLT  = 1'b0;
    localparam logic CH_THERM = 1'b1;

endpackage

// File: rtl/csd_sequencer.sv
// Burst sequencer: starts a burst every PERIOD_CYC cycles and walks
// BURST_LEN conversion points. At each point it converts the voltage channel,
// then the thermistor channel, then idles GAP_CYC cycles.
// Assumes PERIOD_CYC exceeds the burst length in cycles, GAP_CYC >= 1,
// and that adc_ready arrives only for the outstanding request.
module csd_sequencer
    import csd_pkg::*;
#(
    parameter int PERIOD_CYC = 34_000_000,
    parameter int GAP_CYC    = 57,
    parameter int BURST_LEN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic adc_ready,
    output logic adc_start,
    output logic adc_chan,
    output logic cap_v,
    output logic cap_t,
    output logic burst_done
);
    localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_CYC - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [BW-1:0] PT_LAST  = BW'(BURST_LEN - 1);

    seq_state_t      state;
    logic [PW-1:0]   per_cnt;
    logic [GW-1:0]   gap_cnt;
    logic [BW-1:0]   pt_cnt;
    logic            kick;

    // Burst kick at the start of every period
    assign kick = (per_cnt == '0);

    // Period timer, restarted by reset or start
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            per_cnt <= '0;
        end else begin
            per_cnt <= (per_cnt == PER_LAST) ? '0 : per_cnt + 1'b1;
        end
    end

    // Burst state machine and point/gap counters
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state   <= SQ_IDLE;
            gap_cnt <= '0;
            pt_cnt  <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (kick) begin
                    state  <= SQ_REQ_V;
                    pt_cnt <= '0;
                end
                SQ_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        state   <= SQ_REQ_V;
                        gap_cnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                SQ_REQ_V:  state <= SQ_WAIT_V;
                SQ_WAIT_V: if (adc_ready) state <= SQ_REQ_T;
                SQ_REQ_T:  state <= SQ_WAIT_T;
                SQ_WAIT_T: if (adc_ready) begin
                    if (pt_cnt == PT_LAST) begin
                        state <= SQ_DONE;
                    end else begin
                        pt_cnt  <= pt_cnt + 1'b1;
                        gap_cnt <= '0;
                        state   <= SQ_GAP;
                    end
                end
                SQ_DONE:   state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // Handshake and capture strobes decoded from state
    always_comb begin
        adc_start  = (state == SQ_REQ_V) || (state == SQ_REQ_T);
        adc_chan   = ((state == SQ_REQ_T) || (state == SQ_WAIT_T)) ? CH_THERM : CH_VOLT;
        cap_v      = (state == SQ_WAIT_V) && adc_ready;
        cap_t      = (state == SQ_WAIT_T) && adc_ready;
        burst_done = (state == SQ_DONE);
    end

endmodule

// File: rtl/csd_accum.sv
// Burst accumulator for one channel: sums conversion codes and, on done,
// publishes the sum shifted right by SHIFT (floor of the mean of 2^SHIFT codes).
// Assumes exactly 2^SHIFT captures between clears/dones.
module csd_accum #(
    parameter int W     = 10,
    parameter int SHIFT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic [W-1:0] data,
    input  logic         done,
    output logic [W-1:0] avg
);
    localparam int SW = W + SHIFT;

    logic [SW-1:0] sum;

    // Accumulate captures, publish and clear on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            avg <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (done) begin
            avg <= sum[SW-1:SHIFT];
            sum <= '0;
        end else if (cap) begin
            sum <= sum + SW'(data);
        end
    end

endmodule

// File: rtl/csd_dv_test.sv
// Falling-voltage test: keeps the running peak of voltage samples and flags a
// sample that is DROP codes or more below it, inside the window below mcv,
// when enabled and past the hold-off sample count.
// Assumes stb is a one-cycle pulse with v stable in that cycle.
module csd_dv_test #(
    parameter int W    = 10,
    parameter int DROP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb,
    input  logic         en,
    input  logic [W-1:0] v,
    input  logic [W-1:0] mcv,
    input  logic [W-1:0] span,
    input  logic [7:0]   holdoff_n,
    output logic         term
);
    logic [W-1:0] peak;
    logic         peak_ok;
    logic [7:0]   seen;
    logic         in_win;
    logic         dropped;
    logic         held;

    // Window, drop and hold-off qualifiers for the current sample
    always_comb begin
        in_win  = (({1'b0, v} + {1'b0, span}) > {1'b0, mcv}) && (v < mcv);
        dropped = peak_ok && (({1'b0, v} + (W+1)'(DROP)) <= {1'b0, peak});
        held    = (seen < holdoff_n);
    end

    // Flag register, peak tracking and saturating sample count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            term    <= 1'b0;
            peak    <= '0;
            peak_ok <= 1'b0;
            seen    <= '0;
        end else begin
            term <= stb && en && !held && in_win && dropped;
            if (stb) begin
                if (!peak_ok || (v > peak)) peak <= v;
                peak_ok <= 1'b1;
                if (seen != 8'hFF) seen <= seen + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csd_dt_test.sv
// Temperature-rate test: keeps the two previous thermistor samples and flags
// a sample DROP codes or more below the one from two periods back, inside the
// cutoff/fault window, when enabled.
// Assumes stb is a one-cycle pulse with t stable in that cycle.
module csd_dt_test #(
    parameter int W    = 10,
    parameter int DROP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb,
    input  logic         en,
    input  logic [W-1:0] t,
    input  logic [W-1:0] tco,
    input  logic [W-1:0] ltf,
    output logic         term
);
    logic [W-1:0] hist1;
    logic [W-1:0] hist2;
    logic [1:0]   hcnt;
    logic         in_win;
    logic         dropped;

    // Window and two-back drop qualifiers
    always_comb begin
        in_win  = (t > tco) && (t < ltf);
        dropped = (hcnt == 2'd2) && (({1'b0, t} + (W+1)'(DROP)) <= {1'b0, hist2});
    end

    // Flag register and two-deep history shift
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            term  <= 1'b0;
            hist1 <= '0;
            hist2 <= '0;
            hcnt  <= '0;
        end else begin
            term <= stb && en && in_win && dropped;
            if (stb) begin
                hist2 <= hist1;
                hist1 <= t;
                if (hcnt != 2'd2) hcnt <= hcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/charge_slope_detector.sv
// Top: sequences bursts on the converter, averages both channels and runs the
// falling-voltage and temperature-rate termination tests once per sample.
// Flags appear one cycle after sample_stb. Assumes the converter answers each
// request with exactly one adc_ready pulse.
module charge_slope_detector #(
    parameter int ADC_W      = 10,
    parameter int AVG_SHIFT  = 4,
    parameter int GAP_CYC    = 57,
    parameter int PERIOD_CYC = 34_000_000,
    parameter int DV_DROP    = 3,
    parameter int DT_DROP    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dv_en,
    input  logic             dt_en,
    input  logic [7:0]       holdoff_samples,
    input  logic [ADC_W-1:0] mcv_lvl,
    input  logic [ADC_W-1:0] span_lvl,
    input  logic [ADC_W-1:0] tco_lvl,
    input  logic [ADC_W-1:0] ltf_lvl,
    output logic             adc_start,
    output logic             adc_chan,
    input  logic             adc_ready,
    input  logic [ADC_W-1:0] adc_data,
    output logic             sample_stb,
    output logic [ADC_W-1:0] v_avg,
    output logic [ADC_W-1:0] t_avg,
    output logic             dv_term,
    output logic             dt_term
);
    localparam int BURST_LEN = 1 << AVG_SHIFT;

    logic       cap_v;
    logic       cap_t;
    logic       burst_done;
    logic [1:0] cap_vec;
    logic [1:0][ADC_W-1:0] avg_vec;

    csd_sequencer #(
        .PERIOD_CYC (PERIOD_CYC),
        .GAP_CYC    (GAP_CYC),
        .BURST_LEN  (BURST_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start),
        .adc_ready  (adc_ready),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .cap_v      (cap_v),
        .cap_t      (cap_t),
        .burst_done (burst_done)
    );

    assign cap_vec = {cap_t, cap_v};

    // One accumulator per channel: index 0 voltage, 1 thermistor
    for (genvar ch = 0; ch < 2; ch++) begin : g_acc
        csd_accum #(
            .W     (ADC_W),
            .SHIFT (AVG_SHIFT)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .cap   (cap_vec[ch]),
            .data  (adc_data),
            .done  (burst_done),
            .avg   (avg_vec[ch])
        );
    end

    assign v_avg = avg_vec[0];
    assign t_avg = avg_vec[1];

    // Sample strobe aligned with the published averages
    always_ff @(posedge clk) begin
        if (!rst_n || start) sample_stb <= 1'b0;
        else                 sample_stb <= burst_done;
    end

    csd_dv_test #(
        .W    (ADC_W),
        .DROP (DV_DROP)
    ) u_dv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .stb       (sample_stb),
        .en        (dv_en),
        .v         (v_avg),
        .mcv       (mcv_lvl),
        .span      (span_lvl),
        .holdoff_n (holdoff_samples),
        .term      (dv_term)
    );

    csd_dt_test #(
        .W    (ADC_W),
        .DROP (DT_DROP)
    ) u_dt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .stb   (sample_stb),
        .en    (dt_en),
        .t     (t_avg),
        .tco   (tco_lvl),
        .ltf   (ltf_lvl),
        .term  (dt_term)
    );

endmodule

// File: rtl/csd_checker.sv
// Port-level temporal checks for charge_slope_detector, attached by bind.
module csd_checker #(
    parameter int ADC_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dv_en,
    input logic             dt_en,
    input logic [ADC_W-1:0] mcv_lvl,
    input logic [ADC_W-1:0] tco_lvl,
    input logic [ADC_W-1:0] ltf_lvl,
    input logic             adc_start,
    input logic             sample_stb,
    input logic [ADC_W-1:0] v_avg,
    input logic [ADC_W-1:0] t_avg,
    input logic             dv_term,
    input logic             dt_term
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R1
    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R1
    AST_DV_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        dv_term |-> $past(sample_stb)); // R9
    AST_DT_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        dt_term |-> $past(sample_stb)); // R9
    AST_DV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dv_term |=> !dv_term); // R9
    AST_DV_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        dv_term |-> $past(dv_en)); // R6
    AST_DV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dv_term |-> $past(v_avg < mcv_lvl)); // R4
    AST_DT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dt_term |-> $past(dt_en && (t_avg > tco_lvl) && (t_avg < ltf_lvl))); // R7
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!dv_term && !dt_term)); // R8
endmodule

bind charge_slope_detector csd_checker #(.ADC_W(ADC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dv_en      (dv_en),
    .dt_en      (dt_en),
    .mcv_lvl    (mcv_lvl),
    .tco_lvl    (tco_lvl),
    .ltf_lvl    (ltf_lvl),
    .adc_start  (adc_start),
    .sample_stb (sample_stb),
    .v_avg      (v_avg),
    .t_avg      (t_avg),
    .dv_term    (dv_term),
    .dt_term    (dt_term)
);

// File: tb/tb_charge_slope_detector.sv
`timescale 1ns/1ps
module tb_charge_slope_detector;
    localparam int W      = 10;
    localparam int SH     = 4;
    localparam int GAP    = 3;
    localparam int PERIOD = 250;
    localparam int DVD    = 3;
    localparam int DTD    = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dv_en = 1'b1;
    logic         dt_en = 1'b1;
    logic [7:0]   holdoff_samples = 8'd3;
    logic [W-1:0] mcv_lvl = 10'd600;
    logic [W-1:0] span_lvl = 10'd250;
    logic [W-1:0] tco_lvl = 10'd200;
    logic [W-1:0] ltf_lvl = 10'd700;
    logic         adc_start;
    logic         adc_chan;
    logic         adc_ready = 1'b0;
    logic [W-1:0] adc_data = '0;
    logic         sample_stb;
    logic [W-1:0] v_avg;
    logic [W-1:0] t_avg;
    logic         dv_term;
    logic         dt_term;

    charge_slope_detector #(
        .ADC_W(W), .AVG_SHIFT(SH), .GAP_CYC(GAP), .PERIOD_CYC(PERIOD),
        .DV_DROP(DVD), .DT_DROP(DTD)
    ) dut (.*);

    always #4 clk = ~clk; // 125 MHz

    int tests = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;
    int vbase = 500, tbase = 500;
    bit noise_on = 0;
    int vsum = 0, tsum = 0;
    // bench model state
    int pk = 0, seen = 0, h1 = 0, h2 = 0, hc = 0;
    bit pk_ok = 0;
    int last_stb = 0;
    bit skip_iv = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit exp_dv(input int va);
        return dv_en && (seen >= int'(holdoff_samples)) && pk_ok && (va + DVD <= pk)
               && (va + int'(span_lvl) > int'(mcv_lvl)) && (va < int'(mcv_lvl));
    endfunction

    function automatic bit exp_dt(input int ta);
        return dt_en && (hc == 2) && (ta > int'(tco_lvl)) && (ta < int'(ltf_lvl)) && (ta + DTD <= h2);
    endfunction

    // Converter model: fixed latency, records codes per channel
    initial begin
        int pend = 0;
        bit pch = 0;
        int val;
        forever begin
            @(negedge clk);
            adc_ready = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    val = (pch ? tbase : vbase) + (noise_on ? int'($urandom % 4) : 0);
                    adc_data = W'(val);
                    adc_ready = 1'b1;
                    if (pch) tsum += val; else vsum += val;
                end
            end else if (rst_n && adc_start) begin
                pend = 2;
                pch = adc_chan;
            end
        end
    end

    task automatic model_restart();
        pk = 0; pk_ok = 0; seen = 0; h1 = 0; h2 = 0; hc = 0; skip_iv = 1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model_restart();
    endtask

    // Wait for one sample, check averages, spacing and flags, update model
    task automatic run_sample(input string tag);
        int ev, et;
        bit edv, edt;
        do @(negedge clk); while (!sample_stb);
        ev = vsum >> SH; et = tsum >> SH;
        vsum = 0; tsum = 0;
        chk(int'(v_avg) == ev, "R1 voltage average", int'(v_avg), ev);
        chk(int'(t_avg) == et, "R1 thermistor average", int'(t_avg), et);
        chk(!dv_term && !dt_term, "R9 no flag in strobe cycle", {dv_term, dt_term}, 0);
        if (!skip_iv) chk(cyc - last_stb == PERIOD, "R2 sample spacing", cyc - last_stb, PERIOD);
        last_stb = cyc; skip_iv = 0;
        edv = exp_dv(ev); edt = exp_dt(et);
        @(negedge clk);
        chk(dv_term == edv, {"R3/R4/R5/R6/R8 dv_term ", tag}, dv_term, edv);
        chk(dt_term == edt, {"R7/R8 dt_term ", tag}, dt_term, edt);
        if (!pk_ok || ev > pk) pk = ev;
        pk_ok = 1;
        if (seen < 255) seen++;
        h2 = h1; h1 = et; if (hc < 2) hc++;
        @(negedge clk);
        chk(!dv_term && !dt_term, "R9 single-cycle flags", {dv_term, dt_term}, 0);
    endtask

    task automatic set_vt(input int v, input int t);
        vbase = v; tbase = t;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!adc_start && !dv_term && !dt_term && !sample_stb, "R9 reset outputs idle",
            {adc_start, dv_term, dt_term, sample_stb}, 0);
        model_restart();
        set_vt(500, 500);
        rst_n = 1'b1;
        // hold-off: drop at sample 2 masked (R5), at sample 3 terminates (R3)
        run_sample("s0");
        set_vt(520, 500); run_sample("s1");
        set_vt(510, 500); run_sample("R5 masked drop");
        chk(dv_term == 0, "R5 hold-off masks drop", dv_term, 0);
        set_vt(510, 500); run_sample("R3 after hold-off");
        set_vt(400, 400); run_sample("s4");
        // restart clears peak and history (R8)
        pulse_start();
        run_sample("R8 first after start");
        set_vt(400, 390); run_sample("R8 second after start");
        set_vt(400, 397); run_sample("R7 two-back drop, R5 dt unmasked");
        set_vt(397, 398); run_sample("R3 drop equal to threshold");
        set_vt(398, 397); run_sample("R3 drop one short");
        dv_en = 1'b0;
        set_vt(380, 397); run_sample("R6 disabled");
        dv_en = 1'b1;
        set_vt(340, 700); run_sample("R4 below window / R7 at ltf");
        set_vt(600, 200); run_sample("R4 at mcv / R7 at tco");
        set_vt(590, 650); run_sample("R4 inside window");
        // random phase
        noise_on = 1;
        for (int i = 0; i < 48; i++) begin
            dv_en = ($urandom % 4) != 0;
            dt_en = ($urandom % 4) != 0;
            holdoff_samples = 8'($urandom % 4);
            if (($urandom % 10) == 0) pulse_start();
            set_vt(330 + int'($urandom % 300), 150 + int'($urandom % 600));
            run_sample("random");
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule